// File: doc/BRIEF.md
# Multi-Target FPGA Configuration Sequencer

This block loads one or more slave FPGAs through their configuration pins. A start pulse, together with an image size in bytes, launches a sequence with four phases. The block first pulls the shared program line low and waits for the slaves' INIT line to fall. It then releases the program line and waits for INIT to rise again. Next it streams the image into each target in turn. Last, it waits for the shared DONE line. Both INIT waits share one timer, which is armed when the program line is pulled low. The DONE wait gets a timer of its own. Each timeout ends the run with its own error code.

Image words reach the block through a valid/ready input. Each 32-bit word is sent as four byte writes on a 16-bit configuration bus. Targets are loaded one after another. Each target has an active-low select line and an active-high interrupt-enable line, and each has an address window on the bus. The select moves one bit lower for every new target. After a target's data, the block issues four empty read strobes, which act as trailing configuration clocks. It repeats four such strobes for every target once all targets are loaded. The timeout is counted in ticks of a free-running prescaler. INIT and DONE are synchronised before the block uses them.

Top module: `fpga_cfg_seq`

## Requirements
- R1: After reset, and while idle, the block holds `prog_pin` high, all `cfg_sel_n` bits high, all `irq_sel` bits low, `bus_wr`, `bus_rd`, `src_ready`, `busy` and `pass` low, and `err_code` at 0.
- R2: A start pulse drives `prog_pin` low. If the synchronised INIT does not fall before the timer expires, the run ends with `err_code` = 1, `prog_pin` stays low, and no bus strobe is issued.
- R3: Once INIT is low, `prog_pin` goes high and the block waits for INIT to rise, using the same timer. If the timer expires first, `prog_pin` is driven low and the run ends with `err_code` = 2.
- R4: Each target consumes `img_bytes/4 + 1` words (integer division) from the input. A word is taken on a clock edge where `src_valid` and `src_ready` are both high.
- R5: Each word becomes four consecutive write strobes, most significant byte first. The byte sits on `bus_data[15:8]` and `bus_data[7:0]` is 0.
- R6: Target k (counting from 0) drives `cfg_sel_n[NUM_TGT-1-k]` low and `irq_sel[NUM_TGT-1-k]` high from its first word until its trailing reads are done. At most one select is active at any time, and all selects are released between targets.
- R7: After a target's last write, four read strobes follow while its select is still low. All strobes for target k carry `bus_addr` = k·2^STRIDE_LOG2.
- R8: After the last target, four read strobes are issued for each target in target order, at that target's address, with all selects high.
- R9: After the final reads, a fresh timer is armed. If DONE goes high, the run ends with `pass` high and `prog_pin` high. If the timer expires first, `prog_pin` is driven low and the run ends with `err_code` = 3.
- R10: `busy` rises on the edge that takes the start pulse and falls when the run ends with a result. A start pulse while busy is ignored. A start pulse after a result begins a new run and clears the previous result.
- R11: A timeout fires after more than TMO_TICKS ticks, with one tick every TICK_DIV clock cycles, counted from the moment the timer is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run |
| img_bytes | input | LEN_W | Image size in bytes, sampled with start |
| src_valid | input | 1 | Image word available |
| src_data | input | 32 | Image word |
| src_ready | output | 1 | Block takes a word this cycle if valid |
| init_pin | input | 1 | Asynchronous INIT line from the slaves |
| done_pin | input | 1 | Asynchronous DONE line from the slaves |
| prog_pin | output | 1 | Program line (low = hold slaves in reset) |
| cfg_sel_n | output | NUM_TGT | Per-target configuration select, active low |
| irq_sel | output | NUM_TGT | Per-target interrupt-enable select, active high |
| bus_addr | output | ADDR_W | Base address of the current target |
| bus_data | output | 16 | Configuration byte in bits 15:8 |
| bus_wr | output | 1 | Byte write strobe |
| bus_rd | output | 1 | Empty read strobe (trailing clock) |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Last run succeeded |
| err_code | output | 2 | 0 none, 1 INIT fall timeout, 2 INIT rise timeout, 3 DONE timeout |

## Verification
`busy` and the low level on `prog_pin` appear one cycle after the edge that takes the start pulse, and the bench checks them at the next falling edge. A change on INIT or DONE reaches the sequencer after the two-flop synchroniser and acts on the edge after that. Every strobe is compared on the falling edge of the cycle in which it is high. The first write follows the edge that takes a word by exactly one cycle, and the four byte writes fill four consecutive cycles. The scoreboard queue holds the expected address, data, select pattern and strobe kind in order, so it catches a stall, a reordering or an extra strobe. Timeouts can start on any phase of the free-running prescaler, so the bench counts the cycles from start to the end of the run and accepts a window one tick wide.

// File: rtl/fcs_pkg.sv
// Shared types for the configuration sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package fcs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RESET_WAIT,
        ST_INIT_WAIT,
        ST_FETCH,
        ST_BYTE,
        ST_TAIL,
        ST_RELEASE,
        ST_FINAL,
        ST_DONE_WAIT,
        ST_PASS,
        ST_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE       = 2'd0,
        ERR_INIT_START = 2'd1,
        ERR_INIT_EXIT  = 2'd2,
        ERR_DONE       = 2'd3
    } err_t;

endpackage

// File: rtl/fcs_sync.sv
// Two-flop synchroniser for a group of independent asynchronous bits.
// Assumes: each bit is quasi-static, so bits need no coherence with one another.
module fcs_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fcs_timer.sv
// Timeout timer: a free-running prescaler produces ticks, and a saturating
// counter counts the ticks since the last clear. expired goes high once more
// than TMO_TICKS ticks have been counted.
// Assumes: clr is a one-cycle pulse given when a wait phase is entered.
module fcs_timer #(
    parameter int TICK_DIV  = 200,
    parameter int TMO_TICKS = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int DW = $clog2(TICK_DIV > 1 ? TICK_DIV : 2);
    localparam int EW = $clog2(TMO_TICKS + 2);

    logic [DW-1:0] div_q;
    logic [EW-1:0] elapsed_q;
    logic          tick;

    assign tick    = (div_q == DW'(TICK_DIV - 1));
    assign expired = (elapsed_q > EW'(TMO_TICKS));

    // Free-running prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end

    // Tick counter since the last clear, holding once it has expired.
    always_ff @(posedge clk) begin
        if (!rst_n)                 elapsed_q <= '0;
        else if (clr)               elapsed_q <= '0;
        else if (tick && !expired)  elapsed_q <= elapsed_q + 1'b1;
    end
endmodule

// File: rtl/fpga_cfg_seq.sv
// Configuration sequencer for NUM_TGT slave FPGAs. It drives the program
// line, waits for the INIT handshake, streams the image bytes to each target
// under a walking select, issues trailing read strobes, then checks DONE.
// Assumes: ADDR_W >= STRIDE_LOG2 + bits(NUM_TGT); the host supplies
// img_bytes/4+1 words for each target.
module fpga_cfg_seq
    import fcs_pkg::*;
#(
    parameter int NUM_TGT     = 2,
    parameter int LEN_W       = 20,
    parameter int ADDR_W      = 24,
    parameter int STRIDE_LOG2 = 20,
    parameter int TICK_DIV    = 200,
    parameter int TMO_TICKS   = 3000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [LEN_W-1:0]    img_bytes,
    input  logic                src_valid,
    input  logic [31:0]         src_data,
    output logic                src_ready,
    input  logic                init_pin,
    input  logic                done_pin,
    output logic                prog_pin,
    output logic [NUM_TGT-1:0]  cfg_sel_n,
    output logic [NUM_TGT-1:0]  irq_sel,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [15:0]         bus_data,
    output logic                bus_wr,
    output logic                bus_rd,
    output logic                busy,
    output logic                pass,
    output logic [1:0]          err_code
);
    localparam int TW  = $clog2(NUM_TGT > 1 ? NUM_TGT : 2);
    localparam int WCW = LEN_W - 2;
    localparam logic [TW-1:0] LAST_TGT = TW'(NUM_TGT - 1);

    seq_state_t     state;
    logic [TW-1:0]  tgt;
    logic [WCW-1:0] wcnt;
    logic [WCW-1:0] last_w;
    logic [31:0]    word_q;
    logic [1:0]     bidx;
    logic [1:0]     rcnt;
    logic           prog_q;
    err_t           err_q;
    logic           init_s, done_s;
    logic           tmo_clr, tmo_exp;
    logic           idle_like, load_win;
    logic [7:0]     cur_byte;

    fcs_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({init_pin, done_pin}),
        .q     ({init_s, done_s})
    );

    fcs_timer #(.TICK_DIV(TICK_DIV), .TMO_TICKS(TMO_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmo_clr),
        .expired (tmo_exp)
    );

    assign idle_like = (state == ST_IDLE) || (state == ST_PASS) || (state == ST_FAIL);
    assign load_win  = (state == ST_FETCH) || (state == ST_BYTE) || (state == ST_TAIL);

    // Arm the timer on entry to the reset phase and to the DONE wait.
    assign tmo_clr = (idle_like && start) ||
                     (state == ST_FINAL && rcnt == 2'd3 && tgt == LAST_TGT);

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            tgt    <= '0;
            wcnt   <= '0;
            last_w <= '0;
            word_q <= '0;
            bidx   <= '0;
            rcnt   <= '0;
            prog_q <= 1'b1;
            err_q  <= ERR_NONE;
        end else begin
            case (state)
                ST_IDLE, ST_PASS, ST_FAIL: begin
                    if (start) begin
                        state  <= ST_RESET_WAIT;
                        prog_q <= 1'b0;
                        err_q  <= ERR_NONE;
                        last_w <= img_bytes[LEN_W-1:2];
                        tgt    <= '0;
                        wcnt   <= '0;
                    end
                end
                ST_RESET_WAIT: begin
                    if (!init_s) begin
                        prog_q <= 1'b1;
                        state  <= ST_INIT_WAIT;
                    end else if (tmo_exp) begin
                        err_q  <= ERR_INIT_START;
                        state  <= ST_FAIL;
                    end
                end
                ST_INIT_WAIT: begin
                    if (init_s) begin
                        state  <= ST_FETCH;
                    end else if (tmo_exp) begin
                        prog_q <= 1'b0;
                        err_q  <= ERR_INIT_EXIT;
                        state  <= ST_FAIL;
                    end
                end
                ST_FETCH: begin
                    if (src_valid) begin
                        word_q <= src_data;
                        bidx   <= 2'd0;
                        state  <= ST_BYTE;
                    end
                end
                ST_BYTE: begin
                    bidx <= bidx + 2'd1;
                    if (bidx == 2'd3) begin
                        if (wcnt == last_w) begin
                            wcnt  <= '0;
                            rcnt  <= 2'd0;
                            state <= ST_TAIL;
                        end else begin
                            wcnt  <= wcnt + 1'b1;
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_TAIL: begin
                    rcnt <= rcnt + 2'd1;
                    if (rcnt == 2'd3) state <= ST_RELEASE;
                end
                ST_RELEASE: begin
                    rcnt <= 2'd0;
                    if (tgt == LAST_TGT) begin
                        tgt   <= '0;
                        state <= ST_FINAL;
                    end else begin
                        tgt   <= tgt + 1'b1;
                        state <= ST_FETCH;
                    end
                end
                ST_FINAL: begin
                    rcnt <= rcnt + 2'd1;
                    if (rcnt == 2'd3) begin
                        if (tgt == LAST_TGT) state <= ST_DONE_WAIT;
                        else                 tgt   <= tgt + 1'b1;
                    end
                end
                ST_DONE_WAIT: begin
                    if (done_s) begin
                        state  <= ST_PASS;
                    end else if (tmo_exp) begin
                        prog_q <= 1'b0;
                        err_q  <= ERR_DONE;
                        state  <= ST_FAIL;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Select the current byte, most significant first.
    always_comb begin
        case (bidx)
            2'd0:    cur_byte = word_q[31:24];
            2'd1:    cur_byte = word_q[23:16];
            2'd2:    cur_byte = word_q[15:8];
            default: cur_byte = word_q[7:0];
        endcase
    end

    // Walking select: target k owns bit NUM_TGT-1-k.
    for (genvar g = 0; g < NUM_TGT; g++) begin : g_sel
        assign cfg_sel_n[g] = !(load_win && tgt == TW'(NUM_TGT - 1 - g));
        assign irq_sel[g]   =   load_win && tgt == TW'(NUM_TGT - 1 - g);
    end

    assign src_ready = (state == ST_FETCH);
    assign bus_wr    = (state == ST_BYTE);
    assign bus_rd    = (state == ST_TAIL) || (state == ST_FINAL);
    assign bus_data  = bus_wr ? {cur_byte, 8'h00} : 16'h0000;
    assign bus_addr  = ADDR_W'(tgt) << STRIDE_LOG2;
    assign prog_pin  = prog_q;
    assign busy      = !idle_like;
    assign pass      = (state == ST_PASS);
    assign err_code  = err_q;
endmodule

// File: rtl/fcs_checker.sv
// Protocol checker for fpga_cfg_seq, attached by bind.
// Assumes: it sees only the ports of the top module.
module fcs_checker #(
    parameter int NUM_TGT = 2,
    parameter int ADDR_W  = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               src_ready,
    input logic               prog_pin,
    input logic [NUM_TGT-1:0] cfg_sel_n,
    input logic [15:0]        bus_data,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic               busy,
    input logic               pass,
    input logic [1:0]         err_code
);
    a_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cfg_sel_n));

    a_r6_select_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $countones(~cfg_sel_n) == 1);

    a_r5_low_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> bus_data[7:0] == 8'h00);

    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    a_r3_prog_high_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> prog_pin);

    a_r9_error_holds_prog_low: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'd0) |-> !prog_pin);

    a_r9_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (prog_pin && err_code == 2'd0 && !busy));

    a_r10_busy_ends_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (pass || err_code != 2'd0));

    a_r4_ready_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> busy);
endmodule

bind fpga_cfg_seq fcs_checker #(.NUM_TGT(NUM_TGT), .ADDR_W(ADDR_W)) u_fcs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_ready (src_ready),
    .prog_pin  (prog_pin),
    .cfg_sel_n (cfg_sel_n),
    .bus_data  (bus_data),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .busy      (busy),
    .pass      (pass),
    .err_code  (err_code)
);

// File: tb/tb_fpga_cfg_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected strobes, and a monitor
// compares every strobe the design issues. A slave model answers PROG.
module tb_fpga_cfg_seq;
    localparam int NT   = 2;
    localparam int LW   = 12;
    localparam int AW   = 24;
    localparam int SL   = 20;
    localparam int TDIV = 4;
    localparam int TMO  = 8;

    typedef struct packed {
        logic          rd;
        logic [AW-1:0] addr;
        logic [15:0]   data;
        logic [NT-1:0] cfg_n;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [LW-1:0] img_bytes = '0;
    logic src_valid = 1'b0;
    logic [31:0] src_data = '0;
    logic src_ready, prog_pin, bus_wr, bus_rd, busy, pass;
    logic init_pin = 1'b1, done_pin = 1'b0;
    logic [NT-1:0] cfg_sel_n, irq_sel;
    logic [AW-1:0] bus_addr;
    logic [15:0] bus_data;
    logic [1:0] err_code;

    int n_chk = 0, n_bad = 0, cyc = 0, rd_seen = 0;
    int lo_cnt = 0, hi_cnt = 0, done_after = 0;
    bit fall_en = 1'b1, rise_en = 1'b1, done_en = 1'b1;
    item_t expq[$];

    fpga_cfg_seq #(.NUM_TGT(NT), .LEN_W(LW), .ADDR_W(AW), .STRIDE_LOG2(SL),
                   .TICK_DIV(TDIV), .TMO_TICKS(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .img_bytes(img_bytes),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .init_pin(init_pin), .done_pin(done_pin), .prog_pin(prog_pin),
        .cfg_sel_n(cfg_sel_n), .irq_sel(irq_sel), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .busy(busy), .pass(pass), .err_code(err_code));

    initial forever #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] word_of(int seed, int k, int i);
        return 32'hA1B2C3D4 ^ (32'(seed) * 32'h01030507) ^ (32'(k * 16 + i) * 32'h11111111);
    endfunction

    function automatic logic [NT-1:0] sel_of(int k);
        logic [NT-1:0] v = '1;
        v[NT-1-k] = 1'b0;
        return v;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Slave model: INIT follows PROG after a delay; DONE rises after the final reads.
    always @(negedge clk) begin
        if (!prog_pin) begin
            hi_cnt = 0;
            lo_cnt = lo_cnt + 1;
            done_pin <= 1'b0;
            if (fall_en && lo_cnt >= 4) init_pin <= 1'b0;
        end else begin
            lo_cnt = 0;
            hi_cnt = hi_cnt + 1;
            if (rise_en && !init_pin && hi_cnt >= 4) init_pin <= 1'b1;
            if (done_en && rd_seen >= done_after) done_pin <= 1'b1;
        end
    end

    // Monitor: compare every strobe against the head of the queue (R5 R6 R7 R8).
    always @(negedge clk) begin
        if (rst_n && (bus_wr || bus_rd)) begin
            item_t act;
            act = '{rd: bus_rd, addr: bus_addr, data: bus_data, cfg_n: cfg_sel_n};
            if (bus_rd) rd_seen = rd_seen + 1;
            n_chk++;
            if (expq.size() == 0) begin
                n_bad++;
                $display("FAIL R5/R7 unexpected strobe: actual %0h expected none", act);
            end else begin
                item_t e;
                e = expq.pop_front();
                if (act != e || irq_sel != ~e.cfg_n) begin
                    n_bad++;
                    $display("FAIL R5/R6/R7/R8 strobe: actual %0h irq %0h expected %0h",
                             act, irq_sel, e);
                end
            end
        end
    end

    // Push the whole expected strobe sequence of one run.
    task automatic push_expected(int words, int seed);
        for (int k = 0; k < NT; k++) begin
            for (int i = 0; i < words; i++) begin
                logic [31:0] w = word_of(seed, k, i);
                for (int b = 3; b >= 0; b--)
                    expq.push_back('{rd: 1'b0, addr: AW'(k) << SL,
                                     data: {w[8*b +: 8], 8'h00}, cfg_n: sel_of(k)});
            end
            for (int r = 0; r < 4; r++)
                expq.push_back('{rd: 1'b1, addr: AW'(k) << SL, data: 16'h0, cfg_n: sel_of(k)});
        end
        for (int k = 0; k < NT; k++)
            for (int r = 0; r < 4; r++)
                expq.push_back('{rd: 1'b1, addr: AW'(k) << SL, data: 16'h0, cfg_n: '1});
    endtask

    // Driver: offer the words for every target, optionally with gaps and a start poke.
    task automatic feed(int words, int seed, bit stall, bit poke);
        for (int k = 0; k < NT; k++) begin
            for (int i = 0; i < words; i++) begin
                int guard = 0;
                if (stall && (i % 2 == 1)) repeat (3) @(negedge clk);
                src_valid = 1'b1;
                src_data  = word_of(seed, k, i);
                while (!src_ready && guard < 2000) begin
                    @(negedge clk);
                    guard++;
                end
                @(negedge clk);
                src_valid = 1'b0;
                if (poke && k == 0 && i == 0) begin
                    start = 1'b1;
                    img_bytes = LW'(100);
                    @(negedge clk);
                    start = 1'b0;
                    check(busy == 1'b1, "R10", "busy after start while busy", 32'(busy), 1);
                end
            end
        end
    endtask

    // One complete run; returns the number of cycles from start to end of busy.
    task automatic run_case(string name, int bytes, int seed, bit fe, bit re, bit de,
                            bit stall, bit poke, logic [1:0] exp_err, output int dur);
        int words = bytes / 4 + 1;
        bit data_phase = (exp_err == 2'd0) || (exp_err == 2'd3);
        fall_en = fe; rise_en = re; done_en = de;
        done_after = rd_seen + NT * 8;
        if (data_phase) push_expected(words, seed);
        img_bytes = LW'(bytes);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dur = 1;
        check(busy == 1'b1, "R10", {name, " busy after start"}, 32'(busy), 1);
        check(prog_pin == 1'b0, "R2", {name, " prog low after start"}, 32'(prog_pin), 0);
        if (data_phase) feed(words, seed, stall, poke);
        while (busy && dur < 5000) begin
            @(negedge clk);
            dur++;
        end
        if (exp_err == 2'd0) begin
            check(pass == 1'b1, "R9", {name, " pass"}, 32'(pass), 1);
            check(prog_pin == 1'b1, "R9", {name, " prog high on pass"}, 32'(prog_pin), 1);
        end else begin
            check(pass == 1'b0, "R9", {name, " no pass"}, 32'(pass), 0);
            check(prog_pin == 1'b0, "R2/R3/R9", {name, " prog low on error"}, 32'(prog_pin), 0);
        end
        check(err_code == exp_err, "R2/R3/R9", {name, " error code"}, 32'(err_code), 32'(exp_err));
        check(expq.size() == 0, "R4/R8", {name, " all expected strobes seen"},
              32'(expq.size()), 0);
        check(cfg_sel_n == '1 && irq_sel == '0 && !src_ready, "R1/R6",
              {name, " selects released at end"}, 32'(cfg_sel_n), 32'((1 << NT) - 1));
        expq.delete();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        wait (cyc >= 150000);
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int dur;
        repeat (4) @(negedge clk);
        check(prog_pin == 1'b1, "R1", "prog after reset", 32'(prog_pin), 1);
        check(cfg_sel_n == '1 && irq_sel == '0, "R1", "selects after reset",
              32'({cfg_sel_n, irq_sel}), 32'({{NT{1'b1}}, {NT{1'b0}}}));
        check(!bus_wr && !bus_rd && !src_ready, "R1", "bus idle after reset",
              32'({bus_wr, bus_rd, src_ready}), 0);
        check(!busy && !pass && err_code == 2'd0, "R1", "status after reset",
              32'({busy, pass, err_code}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(prog_pin == 1'b1 && !busy, "R1", "idle after reset release",
              32'({prog_pin, busy}), 2);

        run_case("r4_five_bytes", 5, 1, 1, 1, 1, 0, 0, 2'd0, dur);
        run_case("r4_zero_bytes_stall", 0, 2, 1, 1, 1, 1, 0, 2'd0, dur);
        run_case("r4_eight_bytes", 8, 3, 1, 1, 1, 0, 0, 2'd0, dur);
        run_case("r10_start_while_busy", 7, 4, 1, 1, 1, 1, 1, 2'd0, dur);

        run_case("r2_init_never_falls", 5, 5, 0, 1, 1, 0, 0, 2'd1, dur);
        check(dur >= TMO * TDIV && dur <= (TMO + 1) * TDIV + 4, "R11",
              "timeout duration window", 32'(dur), 32'(TMO * TDIV));

        run_case("r3_init_never_rises", 5, 6, 1, 0, 1, 0, 0, 2'd2, dur);
        run_case("r10_restart_after_error", 3, 7, 1, 1, 1, 0, 0, 2'd0, dur);
        run_case("r9_done_never_rises", 4, 8, 1, 1, 0, 0, 0, 2'd3, dur);

        repeat (10) @(negedge clk);
        check(!bus_wr && !bus_rd && !busy, "R10", "quiet after error end",
              32'({bus_wr, bus_rd, busy}), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule